// File: doc/BRIEF.md
# Auto-Precharge Bank Tracker

This block sits inside a multi-bank SDRAM controller and follows every bank that has a burst open with auto-precharge. It decides the exact cycle in which that bank's precharge begins. A burst can end in one of two ways. It can run to its natural end, which a per-bank burst-complete strobe reports. It can also be cut short by a read or write command to another bank. Either event starts the same start rules.

A read burst starts its precharge at once. A write burst first waits a write-recovery time. That wait is counted from the cycle in which the ending event was registered. When a burst is cut short, the last write beat to the cut bank is the one registered one clock earlier, so that beat gets one extra cycle of recovery. Once precharge has begun, the bank's ready flag stays low for the precharge time.

Each bank has its own small state machine and its own down-counter. All banks decode one shared command port.

Top module: `ap_bank_tracker`

## Requirements
- R1: While reset is held and in the first cycle after it, every `bankReady` bit is 1 and every `preStart` bit is 0.
- R2: A bank holding a read burst with auto-precharge (`cmdWrite`=0, `cmdAutoPre`=1) is cut short by any accepted command (`cmdValid`=1) whose `cmdBank` index differs from its own, whether that command reads or writes. Its `preStart` bit is then high for exactly the one cycle that follows the clock edge that sampled the cutting command.
- R3: A bank holding a write burst with auto-precharge (`cmdWrite`=1) that is cut short in the same way raises `preStart` T_WR cycles later than the R2 rule would. The recovery count starts at the edge that sampled the cutting command.
- R4: A burst with auto-precharge that is not cut short starts its precharge when its `burstDone` bit is sampled high. The read timing of R2 and the write timing of R3 apply, counted from that edge.
- R5: `bankReady` of a bank drops in the cycle after its auto-precharge command is sampled. It stays low through recovery and for T_RP cycles from its `preStart` cycle, and is high again T_RP cycles after `preStart`.
- R6: A burst issued with `cmdAutoPre`=0 never produces `preStart`, whether or not a command to another bank cuts it short. Its `bankReady` stays 1. A `burstDone` pulse for a bank with no auto-precharge pending has no effect.
- R7: A further command to the same bank while its auto-precharge burst is pending does not end that burst. It also does not change whether the burst follows the read or the write rule.
- R8: Commands to other banks during a bank's write recovery or precharge do not change its timing, and each auto-precharge burst yields exactly one `preStart` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A registered read or write command is present this cycle |
| cmdBank | input | $clog2(NUM_BANKS) | Binary index of the bank addressed by the command |
| cmdWrite | input | 1 | 1 = write, 0 = read |
| cmdAutoPre | input | 1 | 1 = burst issued with auto-precharge |
| burstDone | input | NUM_BANKS | Per-bank strobe: the burst of that bank ran to its natural end |
| preStart | output | NUM_BANKS | Per-bank one-cycle pulse: precharge begins |
| bankReady | output | NUM_BANKS | Per-bank flag: no auto-precharge pending and precharge time elapsed |

## Verification
The in-module assertions check several rules on every cycle. They check that a read burst ending in the pending state is followed at once by a precharge start. They check that a write burst ending goes into recovery with no start pulse. They check that a start pulse never lasts two cycles, and that a bank with nothing pending cannot produce a start. They also check that the precharge count releases the ready flag when it ends. What the assertions cannot show is the absolute cycle distance from the cutting command to the pulse and to the return of ready. The directed scenarios measure those distances for all four read/write pairings, for natural burst ends, for bursts without auto-precharge, for repeated commands to the same bank, and for traffic that arrives during recovery.

// File: rtl/apt_pkg.sv
package apt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_AP_BURST    = 2'd1,
    ST_WR_RECOVERY = 2'd2,
    ST_PRECHARGING = 2'd3
  } bankState_t;

  // strobes from a bank controller to its counter
  typedef struct packed {
    logic loadWr;
    logic loadRp;
  } cntStrobe_t;

endpackage

// File: rtl/apt_recovery_cnt.sv
module apt_recovery_cnt
  import apt_pkg::*;
#(
  parameter int T_WR = 2,
  parameter int T_RP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  cntStrobe_t strb,
  output logic       cntZero
);
  localparam int MAXC = (T_WR > T_RP) ? T_WR : T_RP;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (strb.loadWr) begin
      cnt <= CW'(T_WR - 1);
    end else if (strb.loadRp) begin
      cnt <= CW'(T_RP - 1);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  // R3 / R5: the controller never asks for both loads at once
  a_r3_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.loadWr && strb.loadRp));

  // R5: a precharge load always starts a nonzero wait when T_RP exceeds one
  a_r5_rp_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadRp && T_RP > 1) |=> !cntZero);

endmodule

// File: rtl/apt_bank_ctrl.sv
module apt_bank_ctrl
  import apt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hitCmd,
  input  logic       otherCmd,
  input  logic       cmdWrite,
  input  logic       cmdAutoPre,
  input  logic       burstDone,
  input  logic       cntZero,
  output cntStrobe_t strb,
  output logic       preStart,
  output logic       bankReady
);
  bankState_t state, nextState;
  logic       isWrite;
  logic       burstEnd;

  assign burstEnd = otherCmd || burstDone;

  always_comb begin
    nextState = state;
    strb      = '0;
    case (state)
      ST_IDLE: begin
        if (hitCmd && cmdAutoPre) nextState = ST_AP_BURST;
      end
      ST_AP_BURST: begin
        if (burstEnd) begin
          if (isWrite) begin
            nextState   = ST_WR_RECOVERY;
            strb.loadWr = 1'b1;
          end else begin
            nextState   = ST_PRECHARGING;
            strb.loadRp = 1'b1;
          end
        end
      end
      ST_WR_RECOVERY: begin
        if (cntZero) begin
          nextState   = ST_PRECHARGING;
          strb.loadRp = 1'b1;
        end
      end
      ST_PRECHARGING: begin
        if (cntZero) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      isWrite  <= 1'b0;
      preStart <= 1'b0;
    end else begin
      state    <= nextState;
      preStart <= strb.loadRp;
      if (state == ST_IDLE && hitCmd && cmdAutoPre) isWrite <= cmdWrite;
    end
  end

  assign bankReady = (state == ST_IDLE);

  // R2: a read burst that ends starts precharge in the next cycle
  a_r2_read_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AP_BURST && !isWrite && burstEnd) |=> preStart);

  // R3: a write burst that ends enters recovery without a start pulse
  a_r3_write_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_AP_BURST && isWrite && burstEnd) |=> (!preStart && state == ST_WR_RECOVERY));

  // R5: the end of the precharge count releases the ready flag
  a_r5_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PRECHARGING && cntZero) |=> bankReady);

  // R6: nothing pending means no start in the next cycle
  a_r6_idle_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    bankReady |=> !preStart);

  // R8: a start is a single-cycle pulse
  a_r8_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    preStart |=> !preStart);

endmodule

// File: rtl/ap_bank_tracker.sv
module ap_bank_tracker
  import apt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmdValid,
  input  logic [$clog2(NUM_BANKS)-1:0] cmdBank,
  input  logic                         cmdWrite,
  input  logic                         cmdAutoPre,
  input  logic [NUM_BANKS-1:0]         burstDone,
  output logic [NUM_BANKS-1:0]         preStart,
  output logic [NUM_BANKS-1:0]         bankReady
);
  localparam int BANK_W = $clog2(NUM_BANKS);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic       hitCmd;
    logic       otherCmd;
    logic       cntZero;
    cntStrobe_t strb;

    assign hitCmd   = cmdValid && (cmdBank == BANK_W'(i));
    assign otherCmd = cmdValid && (cmdBank != BANK_W'(i));

    apt_bank_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .hitCmd    (hitCmd),
      .otherCmd  (otherCmd),
      .cmdWrite  (cmdWrite),
      .cmdAutoPre(cmdAutoPre),
      .burstDone (burstDone[i]),
      .cntZero   (cntZero),
      .strb      (strb),
      .preStart  (preStart[i]),
      .bankReady (bankReady[i])
    );

    apt_recovery_cnt #(
      .T_WR(T_WR),
      .T_RP(T_RP)
    ) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .strb   (strb),
      .cntZero(cntZero)
    );
  end

  // R1: right after reset every bank is ready with no start pulse
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (bankReady == '1 && preStart == '0));

endmodule

// File: tb/ap_bank_tracker_bench.sv
`timescale 1ns/1ps
module ap_bank_tracker_bench;
  localparam int NB  = 4;
  localparam int TWR = 2;
  localparam int TRP = 3;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  cmdValid = 1'b0;
  logic [$clog2(NB)-1:0] cmdBank = '0;
  logic                  cmdWrite = 1'b0;
  logic                  cmdAutoPre = 1'b0;
  logic [NB-1:0]         burstDone = '0;
  logic [NB-1:0]         preStart;
  logic [NB-1:0]         bankReady;

  int nTests = 0;
  int nFail  = 0;
  int cyc    = 0;
  int lastPre[NB];
  int preCount[NB];
  int readyRise[NB];
  logic [NB-1:0] prevReady = '1;

  always #10 clk = ~clk;

  ap_bank_tracker #(.NUM_BANKS(NB), .T_WR(TWR), .T_RP(TRP)) u_ap_bank_tracker (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdBank(cmdBank),
    .cmdWrite(cmdWrite), .cmdAutoPre(cmdAutoPre), .burstDone(burstDone),
    .preStart(preStart), .bankReady(bankReady)
  );

  // observer: numbers every falling edge and records events per bank
  always @(negedge clk) begin
    cyc = cyc + 1;
    for (int b = 0; b < NB; b++) begin
      if (preStart[b]) begin
        lastPre[b]  = cyc;
        preCount[b] = preCount[b] + 1;
      end
      if (bankReady[b] && !prevReady[b]) readyRise[b] = cyc;
    end
    prevReady = bankReady;
  end

  task automatic check(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    for (int b = 0; b < NB; b++) begin
      lastPre[b] = -1; preCount[b] = 0; readyRise[b] = -1;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  // the command is sampled by the rising edge after cycle t
  task automatic sendCmd(input int b, input bit wr, input bit ap, output int t);
    @(negedge clk); #1;
    cmdValid = 1'b1; cmdBank = b[$clog2(NB)-1:0]; cmdWrite = wr; cmdAutoPre = ap;
    t = cyc;
    @(negedge clk); #1;
    cmdValid = 1'b0; cmdWrite = 1'b0; cmdAutoPre = 1'b0;
  endtask

  task automatic sendDone(input int b, output int t);
    @(negedge clk); #1;
    burstDone[b] = 1'b1;
    t = cyc;
    @(negedge clk); #1;
    burstDone = '0;
  endtask

  task automatic testReset();
    check("R1 ready in reset", int'(bankReady), (1 << NB) - 1);
    check("R1 no start in reset", int'(preStart), 0);
    @(negedge clk); #1; rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 ready after reset", int'(bankReady), (1 << NB) - 1);
    check("R1 no start after reset", int'(preStart), 0);
  endtask

  task automatic testInterrupt(input int a, input int b, input bit aWr, input bit bWr,
                               input string req);
    int t0, t1, expPre;
    clearStats();
    sendCmd(a, aWr, 1'b1, t0);
    check({req, " R5 ready drops"}, int'(bankReady[a]), 0);
    sendCmd(b, bWr, 1'b0, t1);
    idle(TWR + TRP + 6);
    expPre = t1 + 1 + (aWr ? TWR : 0);
    check({req, " start cycle"}, lastPre[a], expPre);
    check({req, " R8 one pulse"}, preCount[a], 1);
    check({req, " R5 ready return"}, readyRise[a], expPre + TRP);
    check({req, " R6 cutting bank no start"}, preCount[b], 0);
  endtask

  task automatic testNatural(input int a, input bit aWr);
    int t0, t1, expPre;
    clearStats();
    sendCmd(a, aWr, 1'b1, t0);
    idle(2);
    check("R4 no start before burst end", preCount[a], 0);
    sendDone(a, t1);
    idle(TWR + TRP + 6);
    expPre = t1 + 1 + (aWr ? TWR : 0);
    check("R4 natural end start cycle", lastPre[a], expPre);
    check("R5 natural end ready return", readyRise[a], expPre + TRP);
  endtask

  task automatic testNoAutoPre();
    int t0, t1, t2;
    clearStats();
    sendCmd(0, 1'b0, 1'b0, t0);
    sendCmd(1, 1'b1, 1'b0, t1);
    sendCmd(2, 1'b1, 1'b0, t2);
    sendDone(3, t0);
    idle(TWR + TRP + 6);
    check("R6 read no-AP cut short", preCount[0], 0);
    check("R6 write no-AP cut short", preCount[1], 0);
    check("R6 stray burstDone", preCount[3], 0);
    check("R6 ready stays high", int'(bankReady), (1 << NB) - 1);
  endtask

  task automatic testSameBank();
    int t0, t1, t2;
    clearStats();
    sendCmd(2, 1'b0, 1'b1, t0);
    sendCmd(2, 1'b1, 1'b1, t1);
    idle(TWR + 3);
    check("R7 same-bank command no start", preCount[2], 0);
    check("R7 still pending", int'(bankReady[2]), 0);
    sendDone(2, t2);
    idle(TWR + TRP + 6);
    check("R7 read rule kept", lastPre[2], t2 + 1);
  endtask

  task automatic testBusyTraffic();
    int t0, t1, t2, t3, expPre;
    clearStats();
    sendCmd(0, 1'b1, 1'b1, t0);
    sendCmd(1, 1'b0, 1'b0, t1);
    sendCmd(2, 1'b1, 1'b0, t2);
    sendCmd(3, 1'b0, 1'b0, t3);
    idle(TWR + TRP + 6);
    expPre = t1 + 1 + TWR;
    check("R8 timing kept under traffic", lastPre[0], expPre);
    check("R8 single pulse under traffic", preCount[0], 1);
    check("R8 ready return under traffic", readyRise[0], expPre + TRP);
  endtask

  initial begin
    clearStats();
    idle(3);
    testReset();
    testInterrupt(0, 1, 1'b0, 1'b0, "R2 read cut by read");
    testInterrupt(0, 2, 1'b0, 1'b1, "R2 read cut by write");
    testInterrupt(1, 3, 1'b1, 1'b0, "R3 write cut by read");
    testInterrupt(2, 0, 1'b1, 1'b1, "R3 write cut by write");
    testNatural(3, 1'b0);
    testNatural(1, 1'b1);
    testNoAutoPre();
    testSameBank();
    testBusyTraffic();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    nTests++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule